// File: doc/BRIEF.md
# Receiver Status Interrupt Controller

This block watches the status flags of an audio receiver and raises an active-low interrupt when an unmasked flag changes. The flags are lock loss, invalid sample, transmission error, channel-status/user-data change, non-audio content, copy state, de-emphasis and a multi-bit recovered sample-rate code. Each flag owns one bit in a latched cause register.

Causes are latched in one of two ways. Error-type flags latch as level events, set when the flag rises. Lock loss, non-audio, copy, rate and de-emphasis latch as update signals, set when the value toggles in either direction. The update bit records only that the flag changed. Software reads the live status register to learn the current value.

Software reads and writes registers through a small port with a read strobe. Reading the cause register clears every latched cause.

The block also gates the receiver's sample stream. When both error-type flags are masked from the interrupt, errored samples are replaced without software help. The replacement is all zeros or a repeat of the last good sample, chosen by a fill-mode bit.

Top module: `rx_status_irq_ctrl`

## Requirements
- R1: `irq_no` is high out of reset and is low exactly while some latched cause bit has a 0 in the same bit of the mask register.
- R2: Cause bits 1 (invalid), 2 (transmission error) and 3 (status/user change) are set on a rising edge of their flag. A falling edge sets nothing.
- R3: Cause bits 0 (lock loss), 4 (non-audio), 5 (copy) and 6 (de-emphasis) are set on any toggle of their flag, rising or falling.
- R4: Cause bit 7 is set when any bit of `freq_i` differs from its value on the previous cycle.
- R5: A read strobe to address 0 returns the latched causes on `reg_rdata_o` in the following cycle and clears all cause bits.
- R6: A change detected in the same cycle as the clearing read stays latched after the clear.
- R7: Address 1 reads the registered flags as {0, deemph, copy, non-audio, status change, trans err, invalid, unlock} (bit 7 down to bit 0). Address 3 reads {0…, freq code, fill-mode} with fill-mode in bit 0.
- R8: Address 2 is the mask register, reset to 0. A masked cause still latches and reads back, but it does not drive `irq_no` low.
- R9: When mask bits 1 and 2 are both set and fill-mode (address 3 bit 0, reset 0) is 1, an errored sample leaves as zero one cycle later. A sample counts as errored when it is valid and either the invalid or the transmission-error flag is high.
- R10: Under the same masking with fill-mode 0, an errored sample is replaced by the last good sample received.
- R11: A good sample, or an errored sample while mask bit 1 or mask bit 2 is clear, leaves unchanged one cycle later.
- R12: Flag values present when reset is released are not treated as changes. No cause bit is set in the first cycle after reset.
- R13: `reg_rdata_o` changes only on a read strobe and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unlock_i | input | 1 | Receiver lock lost |
| invalid_i | input | 1 | Validity flag of current sample |
| trans_err_i | input | 1 | Transmission (parity/coding) error |
| csud_i | input | 1 | Channel-status or user data changed |
| non_audio_i | input | 1 | Stream carries non-audio data |
| copy_n_i | input | 1 | Copy flag |
| deemph_i | input | 1 | De-emphasis flag |
| freq_i | input | FREQ_W | Recovered sample-rate code |
| sample_i | input | SAMPLE_W | Incoming audio sample |
| sample_valid_i | input | 1 | Sample strobe |
| sample_o | output | SAMPLE_W | Gated audio sample |
| sample_valid_o | output | 1 | Gated sample strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| irq_no | output | 1 | Interrupt, active low |

## Verification
On every cycle the assertions check the following:
- The cause register never loses a bit except through a clearing read.
- A clearing read leaves exactly the changes detected in that cycle.
- A rising transmission error latches its cause.
- No interrupt appears before the detector is primed after reset.
- Errored samples become zero under full masking with fill-mode 1.
- Good samples pass unchanged.

Only the bench scenarios show the following:
- Which edge sets which cause bit, for each kind of flag.
- The register layouts.
- The effect of the mask on the interrupt pin.
- The repeat of the last good sample.
- That flags present at reset release raise nothing.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int unsigned N_FLAG  = 7;
  localparam int unsigned N_CAUSE = N_FLAG + 1;
  localparam int unsigned DATA_W  = 8;

  localparam int unsigned CI_UNLOCK  = 0;
  localparam int unsigned CI_INVALID = 1;
  localparam int unsigned CI_TERR    = 2;
  localparam int unsigned CI_CSUD    = 3;
  localparam int unsigned CI_NAUDIO  = 4;
  localparam int unsigned CI_COPY    = 5;
  localparam int unsigned CI_DEEMPH  = 6;
  localparam int unsigned CI_FREQ    = 7;

  // flags latched on rising edge only; others on any toggle
  localparam logic [N_FLAG-1:0] RISE_ONLY = 7'b0001110;

  typedef enum logic [1:0] {
    ADDR_CAUSE = 2'd0,
    ADDR_LIVE  = 2'd1,
    ADDR_MASK  = 2'd2,
    ADDR_CTRL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rx_change_detect.sv
module rx_change_detect #(
  parameter int unsigned N_FLAG = 7,
  parameter int unsigned FREQ_W = 2,
  parameter logic [N_FLAG-1:0] RISE_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] flags_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [N_FLAG:0]   hit_o,
  output logic [N_FLAG-1:0] flags_q_o,
  output logic [FREQ_W-1:0] freq_q_o,
  output logic              primed_o
);
  logic              primed_q;
  logic [N_FLAG-1:0] flags_q;
  logic [FREQ_W-1:0] freq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      flags_q  <= '0;
      freq_q   <= '0;
    end else begin
      primed_q <= 1'b1;
      flags_q  <= flags_i;
      freq_q   <= freq_i;
    end
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    if (RISE_MASK[g]) begin : g_rise
      assign hit_o[g] = primed_q & flags_i[g] & ~flags_q[g];
    end else begin : g_toggle
      assign hit_o[g] = primed_q & (flags_i[g] ^ flags_q[g]);
    end
  end

  assign hit_o[N_FLAG] = primed_q & (freq_i != freq_q);
  assign flags_q_o     = flags_q;
  assign freq_q_o      = freq_q;
  assign primed_o      = primed_q;
endmodule

// File: rtl/rx_cause_latch.sv
module rx_cause_latch #(
  parameter int unsigned N_CAUSE = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] hit_i,
  input  logic               clr_i,
  input  logic [N_CAUSE-1:0] mask_i,
  output logic [N_CAUSE-1:0] cause_o,
  output logic               irq_no
);
  logic [N_CAUSE-1:0] cause_q, cause_d;

  // new hits win over the clear
  always_comb cause_d = (clr_i ? '0 : cause_q) | hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign irq_no  = ~|(cause_q & ~mask_i);
endmodule

// File: rtl/rx_sample_gate.sv
module rx_sample_gate #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  input  logic                err_i,
  input  logic                replace_en_i,
  input  logic                fill_zero_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] last_good_q, out_q, out_d;
  logic                valid_q;

  always_comb begin
    out_d = sample_i;
    if (err_i && replace_en_i) out_d = fill_zero_i ? '0 : last_good_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_good_q <= '0;
      out_q       <= '0;
      valid_q     <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        out_q <= out_d;
        if (!err_i) last_good_q <= sample_i;
      end
    end
  end

  assign sample_o = out_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/rx_status_irq_ctrl.sv
module rx_status_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned FREQ_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                unlock_i,
  input  logic                invalid_i,
  input  logic                trans_err_i,
  input  logic                csud_i,
  input  logic                non_audio_i,
  input  logic                copy_n_i,
  input  logic                deemph_i,
  input  logic [FREQ_W-1:0]   freq_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  output logic                irq_no
);
  localparam int unsigned CTRL_USED = FREQ_W + 1;

  logic [N_FLAG-1:0]  flags, flags_q;
  logic [FREQ_W-1:0]  freq_q;
  logic [N_CAUSE-1:0] hit, cause, mask_q;
  logic               primed, fill_q, read_clear, err;
  logic [DATA_W-1:0]  rdata_q, rdata_d;

  always_comb begin
    flags             = '0;
    flags[CI_UNLOCK]  = unlock_i;
    flags[CI_INVALID] = invalid_i;
    flags[CI_TERR]    = trans_err_i;
    flags[CI_CSUD]    = csud_i;
    flags[CI_NAUDIO]  = non_audio_i;
    flags[CI_COPY]    = copy_n_i;
    flags[CI_DEEMPH]  = deemph_i;
  end

  rx_change_detect #(.N_FLAG(N_FLAG), .FREQ_W(FREQ_W), .RISE_MASK(RISE_ONLY)) u_det (
    .clk_i, .rst_ni, .flags_i(flags), .freq_i,
    .hit_o(hit), .flags_q_o(flags_q), .freq_q_o(freq_q), .primed_o(primed)
  );

  assign read_clear = reg_re_i && (reg_addr_i == ADDR_CAUSE);

  rx_cause_latch #(.N_CAUSE(N_CAUSE)) u_cause (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(read_clear), .mask_i(mask_q),
    .cause_o(cause), .irq_no
  );

  assign err = invalid_i | trans_err_i;

  rx_sample_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
    .clk_i, .rst_ni, .sample_i, .valid_i(sample_valid_i), .err_i(err),
    .replace_en_i(mask_q[CI_INVALID] & mask_q[CI_TERR]), .fill_zero_i(fill_q),
    .sample_o, .valid_o(sample_valid_o)
  );

  always_comb begin
    rdata_d = '0;
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CAUSE: rdata_d = DATA_W'(cause);
      ADDR_LIVE:  rdata_d = DATA_W'(flags_q);
      ADDR_MASK:  rdata_d = DATA_W'(mask_q);
      ADDR_CTRL:  rdata_d[CTRL_USED-1:0] = {freq_q, fill_q};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      fill_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_re_i) rdata_q <= rdata_d;
      if (reg_we_i && reg_addr_i == ADDR_MASK) mask_q <= reg_wdata_i[N_CAUSE-1:0];
      if (reg_we_i && reg_addr_i == ADDR_CTRL) fill_q <= reg_wdata_i[0];
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/rx_status_irq_ctrl_chk.sv
module rx_status_irq_ctrl_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned N_CAUSE  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                primed_i,
  input logic                read_clear_i,
  input logic [N_CAUSE-1:0]  hit_i,
  input logic [N_CAUSE-1:0]  cause_i,
  input logic [N_CAUSE-1:0]  mask_i,
  input logic                fill_i,
  input logic                invalid_i,
  input logic                trans_err_i,
  input logic                sample_valid_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                irq_no
);
  // R12: nothing raised before the detector is primed
  a_r12_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_i |-> irq_no);

  // R2
  a_r2_terr_rise_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_i && $rose(trans_err_i)) |=> cause_i[2]);

  // R5, R6
  a_r6_clear_keeps_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_clear_i |=> (cause_i == $past(hit_i)));

  // R5: only a clearing read drops bits
  a_r5_sticky_causes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_clear_i |=> ((cause_i & $past(cause_i)) == $past(cause_i)));

  a_r9_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && (invalid_i || trans_err_i) && mask_i[1] && mask_i[2] && fill_i)
      |=> (sample_o == '0));

  a_r11_good_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !invalid_i && !trans_err_i) |=> (sample_o == $past(sample_i)));
endmodule

bind rx_status_irq_ctrl rx_status_irq_ctrl_chk #(.SAMPLE_W(SAMPLE_W), .N_CAUSE(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .primed_i(primed), .read_clear_i(read_clear),
  .hit_i(hit), .cause_i(cause), .mask_i(mask_q), .fill_i(fill_q),
  .invalid_i(invalid_i), .trans_err_i(trans_err_i), .sample_valid_i(sample_valid_i),
  .sample_i(sample_i), .sample_o(sample_o), .irq_no(irq_no)
);

// File: tb/rx_status_irq_ctrl_test.sv
module rx_status_irq_ctrl_test;
  localparam int SW = 24;
  localparam int FW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, unlock, invalid, terr, csud, naudio, copy_n, deemph;
  logic [FW-1:0] freq;
  logic [SW-1:0] smp_in, smp_out;
  logic smp_vin, smp_vout, we, re, irq_n;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rx_status_irq_ctrl #(.SAMPLE_W(SW), .FREQ_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .unlock_i(unlock), .invalid_i(invalid),
    .trans_err_i(terr), .csud_i(csud), .non_audio_i(naudio), .copy_n_i(copy_n),
    .deemph_i(deemph), .freq_i(freq), .sample_i(smp_in), .sample_valid_i(smp_vin),
    .sample_o(smp_out), .sample_valid_o(smp_vout), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    re = 1'b1; addr = a;
    step();
    re = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic flush();
    logic [7:0] d;
    step();
    rd(2'd0, d);
    step();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    // copy_n held high through reset: must not count as a change
    check("R1 irq idle after reset", irq_n, 1'b1);
    step(); step();
    check("R12 no cause from reset-time flags", irq_n, 1'b1);
    rd(2'd0, d);
    check("R12 cause register empty", d, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] d;
    invalid = 1'b1; step();
    check("R1 irq low on invalid rise", irq_n, 1'b0);
    rd(2'd0, d);
    check("R2 invalid cause bit1", d, 8'h02);
    check("R5 irq released after read", irq_n, 1'b1);
    invalid = 1'b0; step();
    check("R2 falling invalid no irq", irq_n, 1'b1);
    csud = 1'b1; terr = 1'b1; step();
    rd(2'd0, d);
    check("R2 csud+terr bits 3,2", d, 8'h0C);
    csud = 1'b0; terr = 1'b0; step();
    rd(2'd0, d);
    check("R2 falls set nothing", d, 8'h00);
  endtask

  task automatic t_toggles();
    logic [7:0] d;
    unlock = 1'b1; step();
    rd(2'd0, d);
    check("R3 unlock rise bit0", d, 8'h01);
    unlock = 1'b0; deemph = 1'b1; copy_n = 1'b0; naudio = 1'b1; step();
    rd(2'd0, d);
    check("R3 unlock fall, deemph, copy, nonaudio", d, 8'h71);
    deemph = 1'b0; step();
    rd(2'd0, d);
    check("R3 deemph fall bit6", d, 8'h40);
  endtask

  task automatic t_freq();
    logic [7:0] d;
    freq = 2'b10; step();
    check("R4 irq on freq change", irq_n, 1'b0);
    rd(2'd0, d);
    check("R4 freq cause bit7", d, 8'h80);
    step();
    rd(2'd0, d);
    check("R4 steady freq no cause", d, 8'h00);
  endtask

  task automatic t_live();
    logic [7:0] d;
    // current flags: naudio=1, copy_n=0, others 0, freq=10
    invalid = 1'b1; step(); step();
    rd(2'd1, d);
    check("R7 live status layout", d, 8'h12);
    rd(2'd3, d);
    check("R7 ctrl freq and fill", d, 8'h04);
    invalid = 1'b0;
    flush();
  endtask

  task automatic t_collision();
    logic [7:0] d;
    unlock = 1'b1; step();
    csud = 1'b1;
    rd(2'd0, d);
    check("R5 read returns pre-clear causes", d, 8'h01);
    check("R6 change during clear keeps irq", irq_n, 1'b0);
    csud = 1'b0; step();
    check("R13 rdata holds without strobe", rdata, 8'h01);
    rd(2'd0, d);
    check("R6 collided cause retained", d, 8'h08);
    unlock = 1'b0;
    flush();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd2, 8'h01);
    rd(2'd2, d);
    check("R8 mask readback", d, 8'h01);
    unlock = 1'b1; step();
    check("R8 masked cause keeps irq high", irq_n, 1'b1);
    deemph = 1'b1; step();
    check("R8 unmasked cause drives irq", irq_n, 1'b0);
    rd(2'd0, d);
    check("R8 masked cause still latched", d, 8'h41);
    unlock = 1'b0; deemph = 1'b0;
    flush();
  endtask

  task automatic t_samples();
    wr(2'd2, 8'h06);
    wr(2'd3, 8'h01);
    smp_vin = 1'b1; smp_in = 24'h123456; step();
    check("R11 good sample passes", smp_out, 24'h123456);
    check("R11 valid follows", smp_vout, 1'b1);
    invalid = 1'b1; smp_in = 24'hABCDEF; step();
    check("R9 errored sample zeroed", smp_out, 24'h0);
    wr(2'd3, 8'h00);
    invalid = 1'b0; smp_in = 24'h000321; step();
    terr = 1'b1; smp_in = 24'h0FFFFF; step();
    check("R10 errored sample repeats last good", smp_out, 24'h000321);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h01);
    smp_in = 24'h789ABC; step();
    check("R11 errored sample unmasked passes", smp_out, 24'h789ABC);
    terr = 1'b0; smp_vin = 1'b0;
    wr(2'd2, 8'h00);
    flush();
  endtask

  initial begin
    rst_n = 1'b0; unlock = 0; invalid = 0; terr = 0; csud = 0; naudio = 0;
    copy_n = 1'b1; deemph = 0; freq = '0; smp_in = '0; smp_vin = 0;
    we = 0; re = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_events();
    t_toggles();
    t_freq();
    t_live();
    t_collision();
    t_mask();
    t_samples();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule